// File: doc/BRIEF.md
# Drift-Trimmed Nanosecond Time-of-Day Counter

This block keeps a 64-bit time of day in nanoseconds. While it runs, the counter gains one 16 ns quantum on every clock cycle. A drift engine makes small rate corrections to it. The engine counts elapsed quanta. Each time a programmed number of quanta has passed, it bends that cycle's increment up or down by 0 to 7 ns. This lets firmware pull the counter towards a reference clock without ever stepping it.

Control is through a word-wide register port with separate write and read channels. Firmware sets a guard bit that holds the drift engine, writes a new drift word while the guard is set, and then clears the guard to restart the engine from a fresh count. To set the time, firmware sends a pause command, writes the 64-bit value as two halves, and sends a resume command. To read the time, firmware reads the low word and then the high word. The high word is captured when the low word is read, so the two halves always belong to the same instant.

Register addresses: 0 drift word, 1 drift guard (bit 0), 2 run control, 3 load low half, 4 load high half, 5 time low word, 6 time high word. Reads of 3, 4 and 7 return zero.

Top module: `drift_tod_counter`

## Requirements
- R1: After reset, the time is 0 and the counter runs. The drift word, the drift guard and the paused flag read 0, and rd_data is 0.
- R2: While running with no correction due, the time grows by exactly 16 per clock cycle.
- R3: The drift word is laid out as period in bits 27:0 (units of 16 ns quanta), magnitude in bits 30:28 and direction in bit 31. A write to address 0 takes effect only while the drift guard is 1. Otherwise it is ignored and the old word reads back.
- R4: Writing bit 0 of address 1 sets or clears the drift guard, and address 1 reads it back. While the guard is 1, the quanta count is held at zero and no correction is applied.
- R5: With the guard clear and a nonzero period P, a correction falls on the P-th running cycle after the guard was released, and every P running cycles after that. In that cycle the time grows by 16+M when bit 31 is 1, or by 16-M when bit 31 is 0, where M is the magnitude field.
- R6: A period field of zero, which includes a drift word of all zeros, disables correction. The time then grows by exactly 16 per cycle.
- R7: Writing 2 to address 2 pauses the counter from the next cycle on, and writing 4 resumes it. Any other value is ignored. Address 2 reads back 1 in bit 0 while paused.
- R8: While paused, writes to addresses 3 and 4 replace the low and high 32 bits of the time. While running, these writes are ignored.
- R9: A read returns its data on the following cycle. Reading address 5 returns the low time word and captures the high word at the same instant. Address 6 returns that captured word until the next read of address 5.
- R10: The drift engine counts only running cycles, so a pause delays the next correction by the length of the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
The low time word is read on almost every cycle, so each increment is seen individually. Runs with no correction tell a plain 16 ns step apart from a corrected one. The add pattern with a short period and the subtract pattern with a longer period separate the sign and magnitude fields and expose any off-by-one in the correction spacing. A drift word written while the guard is clear, a pause that lands mid-period, and loads written both while running and while paused each show whether a stimulus that should be ignored or deferred changed the time. A load just below a 32-bit carry, followed by a read of the low word, a long gap and then a read of the high word, tells a captured high word apart from a live one.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        REG_DRIFT_WORD  = 3'd0,
        REG_DRIFT_GUARD = 3'd1,
        REG_RUN_CTRL    = 3'd2,
        REG_LOAD_LO     = 3'd3,
        REG_LOAD_HI     = 3'd4,
        REG_TIME_LO     = 3'd5,
        REG_TIME_HI     = 3'd6
    } reg_addr_e;

    localparam logic [WORD_W-1:0] CMD_PAUSE  = 32'd2;
    localparam logic [WORD_W-1:0] CMD_RESUME = 32'd4;

endpackage

// File: rtl/tdc_drift_engine.sv
module tdc_drift_engine #(
    parameter int unsigned PERIOD_W = 28,
    parameter int unsigned MAG_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                hold,
    input  logic [PERIOD_W-1:0] period,
    input  logic [MAG_W-1:0]    mag,
    input  logic                dir_add,
    output logic                corr_evt,
    output logic                corr_add,
    output logic [MAG_W-1:0]    corr_mag
);

    typedef struct packed {
        logic [PERIOD_W-1:0] qcnt;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic       period_off;
    logic       expire;

    always_comb begin
        st_d       = st_q;
        period_off = (period == '0);
        expire     = (st_q.qcnt == period - 1'b1);
        corr_evt   = run && !hold && !period_off && expire;
        if (hold) begin
            st_d.qcnt = '0;
        end else if (run) begin
            if (corr_evt || period_off) begin
                st_d.qcnt = '0;
            end else begin
                st_d.qcnt = st_q.qcnt + 1'b1;
            end
        end
        corr_add = dir_add;
        corr_mag = corr_evt ? mag : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GUARD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q.qcnt == '0)); // R4

    AST_STOPPED_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hold) |=> $stable(st_q.qcnt)); // R10

    AST_COUNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (period != '0) |-> (st_q.qcnt < period)); // R5

endmodule

// File: rtl/tdc_time_core.sv
module tdc_time_core #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned MAG_W   = 3,
    parameter int unsigned QUANTUM = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pause_cmd,
    input  logic                  resume_cmd,
    input  logic                  load_lo_we,
    input  logic                  load_hi_we,
    input  logic [DATA_W-1:0]     load_data,
    input  logic                  corr_evt,
    input  logic                  corr_add,
    input  logic [MAG_W-1:0]      corr_mag,
    output logic [2*DATA_W-1:0]   time_ns,
    output logic                  running
);

    localparam int unsigned TIME_W = 2 * DATA_W;

    typedef struct packed {
        logic [TIME_W-1:0] tod;
        logic              paused;
    } core_state_t;

    core_state_t       st_d, st_q;
    logic [TIME_W-1:0] step;

    always_comb begin
        st_d = st_q;
        step = TIME_W'(QUANTUM);
        if (corr_evt) begin
            if (corr_add) begin
                step = step + TIME_W'(corr_mag);
            end else begin
                step = step - TIME_W'(corr_mag);
            end
        end
        if (!st_q.paused) begin
            st_d.tod = st_q.tod + step;
        end else begin
            if (load_lo_we) begin
                st_d.tod[DATA_W-1:0] = load_data;
            end
            if (load_hi_we) begin
                st_d.tod[TIME_W-1:DATA_W] = load_data;
            end
        end
        if (pause_cmd) begin
            st_d.paused = 1'b1;
        end else if (resume_cmd) begin
            st_d.paused = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_ns = st_q.tod;
    assign running = !st_q.paused;

    AST_PLAIN_QUANTUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !corr_evt) |=> (time_ns == $past(time_ns) + TIME_W'(QUANTUM))); // R2

    AST_ADD_CORRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (running && corr_evt && corr_add)
        |=> (time_ns == $past(time_ns) + TIME_W'(QUANTUM) + TIME_W'($past(corr_mag)))); // R5

    AST_PAUSED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load_lo_we && !load_hi_we) |=> $stable(time_ns)); // R7

    AST_PAUSE_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pause_cmd |=> !running); // R7

endmodule

// File: rtl/tdc_reg_block.sv
module tdc_reg_block
    import tdc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [2:0]          rd_addr,
    input  logic [2*DATA_W-1:0] time_ns,
    input  logic                running,
    output logic [DATA_W-1:0]   drift_word,
    output logic                drift_hold,
    output logic                pause_cmd,
    output logic                resume_cmd,
    output logic                load_lo_we,
    output logic                load_hi_we,
    output logic [DATA_W-1:0]   rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              guard;
        logic [DATA_W-1:0] snap;
        logic [DATA_W-1:0] rdata;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic        wr_word;

    always_comb begin
        st_d       = st_q;
        wr_word    = wr_en && (wr_addr == REG_DRIFT_WORD);
        pause_cmd  = wr_en && (wr_addr == REG_RUN_CTRL) && (wr_data == CMD_PAUSE);
        resume_cmd = wr_en && (wr_addr == REG_RUN_CTRL) && (wr_data == CMD_RESUME);
        load_lo_we = wr_en && (wr_addr == REG_LOAD_LO);
        load_hi_we = wr_en && (wr_addr == REG_LOAD_HI);
        if (wr_word && st_q.guard) begin
            st_d.word = wr_data;
        end
        if (wr_en && (wr_addr == REG_DRIFT_GUARD)) begin
            st_d.guard = wr_data[0];
        end
        if (rd_en) begin
            case (rd_addr)
                REG_DRIFT_WORD:  st_d.rdata = st_q.word;
                REG_DRIFT_GUARD: st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.guard};
                REG_RUN_CTRL:    st_d.rdata = {{(DATA_W-1){1'b0}}, !running};
                REG_TIME_LO: begin
                    st_d.rdata = time_ns[DATA_W-1:0];
                    st_d.snap  = time_ns[2*DATA_W-1:DATA_W];
                end
                REG_TIME_HI:     st_d.rdata = st_q.snap;
                default:         st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drift_word = st_q.word;
    assign drift_hold = st_q.guard;
    assign rd_data    = st_q.rdata;

    AST_WORD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_word && !drift_hold) |=> $stable(drift_word)); // R3

    AST_SNAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && (rd_addr == REG_TIME_LO)) |=> $stable(st_q.snap)); // R9

    AST_ONE_RUN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pause_cmd && resume_cmd)); // R7

endmodule

// File: rtl/drift_tod_counter.sv
module drift_tod_counter #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned PERIOD_W = 28,
    parameter int unsigned MAG_W    = 3,
    parameter int unsigned QUANTUM  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned TIME_W  = 2 * DATA_W;
    localparam int unsigned MAG_LSB = PERIOD_W;
    localparam int unsigned DIR_BIT = PERIOD_W + MAG_W;

    logic [DATA_W-1:0] drift_word;
    logic              drift_hold;
    logic              pause_cmd, resume_cmd;
    logic              load_lo_we, load_hi_we;
    logic [TIME_W-1:0] time_ns;
    logic              running;
    logic              corr_evt, corr_add;
    logic [MAG_W-1:0]  corr_mag;

    tdc_reg_block #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .time_ns    (time_ns),
        .running    (running),
        .drift_word (drift_word),
        .drift_hold (drift_hold),
        .pause_cmd  (pause_cmd),
        .resume_cmd (resume_cmd),
        .load_lo_we (load_lo_we),
        .load_hi_we (load_hi_we),
        .rd_data    (rd_data)
    );

    tdc_drift_engine #(.PERIOD_W(PERIOD_W), .MAG_W(MAG_W)) u_drift (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .hold     (drift_hold),
        .period   (drift_word[PERIOD_W-1:0]),
        .mag      (drift_word[MAG_LSB +: MAG_W]),
        .dir_add  (drift_word[DIR_BIT]),
        .corr_evt (corr_evt),
        .corr_add (corr_add),
        .corr_mag (corr_mag)
    );

    tdc_time_core #(.DATA_W(DATA_W), .MAG_W(MAG_W), .QUANTUM(QUANTUM)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_cmd  (pause_cmd),
        .resume_cmd (resume_cmd),
        .load_lo_we (load_lo_we),
        .load_hi_we (load_hi_we),
        .load_data  (wr_data),
        .corr_evt   (corr_evt),
        .corr_add   (corr_add),
        .corr_mag   (corr_mag),
        .time_ns    (time_ns),
        .running    (running)
    );

    AST_NO_CORR_UNDER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        drift_hold |-> !corr_evt); // R4

    AST_NO_CORR_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (drift_word[PERIOD_W-1:0] == '0) |-> !corr_evt); // R6

endmodule

// File: tb/drift_tod_counter_test.sv
module drift_tod_counter_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    drift_tod_counter uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    longint unsigned m_time;
    longint unsigned m_q;
    logic [31:0]     m_word;
    bit              m_guard;
    bit              m_paused;
    logic [31:0]     m_snap;
    bit              pend;
    logic [31:0]     exp_rd;
    string           exp_tag;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_time = 0; m_q = 0; m_word = 0; m_guard = 0;
            m_paused = 0; m_snap = 0; pend = 0;
        end else begin
            longint unsigned per;
            longint unsigned mg;
            bit evt;
            pend = rd_en;
            exp_tag = tag;
            if (rd_en) begin
                case (rd_addr)
                    3'd0: exp_rd = m_word;
                    3'd1: exp_rd = {31'd0, m_guard};
                    3'd2: exp_rd = {31'd0, m_paused};
                    3'd5: begin exp_rd = m_time[31:0]; m_snap = m_time[63:32]; end
                    3'd6: exp_rd = m_snap;
                    default: exp_rd = 0;
                endcase
            end
            per = longint'(m_word[27:0]);
            mg  = longint'(m_word[30:28]);
            if (!m_paused) begin
                evt = !m_guard && per != 0 && m_q == per - 1;
                m_time += 16;
                if (evt) m_time = m_word[31] ? m_time + mg : m_time - mg;
                if (m_guard || per == 0 || evt) m_q = 0; else m_q++;
            end else if (m_guard) begin
                m_q = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: if (m_guard) m_word = wr_data;
                    3'd1: m_guard = wr_data[0];
                    3'd2: begin
                        if (wr_data == 2) m_paused = 1;
                        else if (wr_data == 4) m_paused = 0;
                    end
                    3'd3: if (m_paused) m_time[31:0] = wr_data;
                    3'd4: if (m_paused) m_time[63:32] = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && pend) begin
            checks++;
            if (rd_data !== exp_rd) begin
                errors++;
                $display("FAIL %s: rd_data actual %h expected %h", exp_tag, rd_data, exp_rd);
            end
        end
    end

    task automatic drive(input bit we, input logic [2:0] wa, input logic [31:0] wd,
                         input bit re, input logic [2:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b1, 3'd5);
    endtask

    task automatic rd(input logic [2:0] a);
        drive(1'b0, 3'd0, 32'd0, 1'b1, a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) rd(3'd5);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: output clear during reset
        checks++;
        if (rd_data !== 32'd0) begin
            errors++;
            $display("FAIL R1: rd_data in reset actual %h expected 00000000", rd_data);
        end
        rst_n = 1'b1;
        tag = "R1";
        rd(3'd0); rd(3'd1); rd(3'd2); rd(3'd5); rd(3'd6);
        tag = "R2";
        idle(6);
        tag = "R3";   // word write ignored with guard clear
        wr(3'd0, 32'h9000_0003);
        rd(3'd0);
        tag = "R4";   // guard set, engine held
        wr(3'd1, 32'd1);
        rd(3'd1);
        wr(3'd0, 32'hD000_0003);   // add, magnitude 5, period 3
        tag = "R3";
        rd(3'd0);
        tag = "R4";
        idle(8);
        tag = "R5";
        wr(3'd1, 32'd0);
        idle(12);
        rd(3'd1);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'h7000_0005);   // subtract, magnitude 7, period 5
        wr(3'd1, 32'd0);
        idle(15);
        tag = "R10";
        idle(2);
        wr(3'd2, 32'd2);
        idle(4);
        wr(3'd2, 32'd4);
        idle(10);
        tag = "R7";
        wr(3'd2, 32'd2);
        idle(3);
        rd(3'd2);
        wr(3'd2, 32'd1);
        idle(3);
        rd(3'd2);
        wr(3'd2, 32'd4);
        rd(3'd2);
        idle(3);
        tag = "R8";
        wr(3'd3, 32'h0000_1234);
        idle(2);
        wr(3'd2, 32'd2);
        wr(3'd3, 32'hFFFF_FF00);
        wr(3'd4, 32'h0000_0001);
        rd(3'd5); rd(3'd6);
        wr(3'd2, 32'd4);
        idle(4);
        tag = "R9";
        rd(3'd5);
        for (int i = 0; i < 20; i++) rd(3'd0);
        rd(3'd6);
        rd(3'd5);
        rd(3'd6);
        tag = "R6";
        wr(3'd1, 32'd1);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        idle(20);
        drive(1'b0, 3'd0, 32'd0, 1'b0, 3'd0);
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        @(negedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: cycles actual %0d expected below 20000", cycles);
        finish_run();
    end

endmodule